// File: doc/BRIEF.md
# Thread and Processor Enable Toggle Unit

This unit carries out four control instructions that each return the old contents of a control register and then force one enable bit of that register to 0 or 1. One register is private to the issuing processing element and holds a thread-enable bit. The other register spans all processing elements and holds a processor-enable bit. The read of the old value and the bit update happen at the same clock edge, so no other event can fall between them.

The issuing pipeline presents a 32-bit instruction word with a valid strobe. Alongside it come three qualifiers: the coprocessor-0 access permission, a flag that says the multithreading extension is present, and a flag that says the issuer is the master element. One cycle after acceptance the unit commits. It updates the selected register, drives the old value toward the destination general register, and pulses a completion strobe. If the instruction faults, it raises one of two exception strobes instead. Words that are not one of the four instructions are dropped silently.

Top module: `mtc_unit`

## Requirements
- R1: While reset is asserted and after it is released, the thread register equals parameter THR_RST and the processor register equals VP_RST. `op_done`, `gpr_we`, `exc_cop_unusable` and `exc_reserved` are 0.
- R2: A word is recognised only when all of the following hold: bits [31:26]=001000, bits [20:17]=0000, bits [15:14]=00, bits [13:11]=001, bits [9:3]=1010110 and bits [2:0]=000. Any other word has no effect. It produces no `op_done`, no write and no register change.
- R3: A recognised word accepted at edge N produces `op_done` high for one cycle after edge N+1. In that same cycle, `gpr_data` holds the selected register's value from before the update, and `gpr_idx` equals word bits [25:21].
- R4: When bits [25:21] are zero, `gpr_we` stays 0. The register update still takes place.
- R5: With bit 16 = 1, the thread register is selected. Bit 10 (0 = clear, 1 = set) is written to bit TE_POS of that register, and every other bit of the register is unchanged.
- R6: With bit 16 = 0, the processor register is selected. When the master flag is 1, bit 10 is written to bit EVP_POS, and the other bits are unchanged.
- R7: When the master flag is 0, a processor-register instruction leaves that register unchanged. It still returns the old value with `gpr_we` set when rt is nonzero.
- R8: If coprocessor-0 access is disabled, `exc_cop_unusable` pulses together with `op_done`. There is no write and neither register changes.
- R9: If access is enabled but the extension is absent, `exc_reserved` pulses together with `op_done`, with no write and no change. A disabled access takes priority, so the two exception strobes are never high together.
- R10: Instructions on consecutive cycles are each committed in order. Each one returns the value left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word |
| cop0_enabled | input | 1 | Coprocessor-0 access permitted |
| mt_present | input | 1 | Multithreading extension implemented |
| is_master | input | 1 | Issuer is the master processing element |
| op_done | output | 1 | One-cycle completion strobe |
| gpr_we | output | 1 | Destination register write enable |
| gpr_idx | output | 5 | Destination register index |
| gpr_data | output | 32 | Old register value to write |
| exc_cop_unusable | output | 1 | Coprocessor-unusable exception strobe |
| exc_reserved | output | 1 | Reserved-instruction exception strobe |
| thr_ctl | output | 32 | Current thread control register |
| vp_ctl | output | 32 | Current processor control register |

## Verification
The bench sets TE_POS to 5 and EVP_POS to 9, so neither enable bit sits at an end of the word. It also uses nonzero reset patterns (A5A50000 and 00003C00 in hex) with zeros at both enable positions. With these values, a returned old value proves that whole words are copied, not just the enable bit. A slip in a shift or a mask also becomes visible in the neighbouring bits. Back-to-back issue tests the read-after-update ordering between adjacent instructions.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned MTC_W  = 32;
  localparam int unsigned MTC_RW = 5;

  // fixed fields of the four control instructions
  localparam logic [5:0] OPC_MAJOR = 6'b001000;
  localparam logic [2:0] SEL_CODE  = 3'b001;
  localparam logic [6:0] FUNC_CODE = 7'b1010110;

  typedef struct packed {
    logic              hit;    // word is one of the four instructions
    logic              to_vp;  // 1: processor register, 0: thread register
    logic              sc;     // value written into the enable bit
    logic [MTC_RW-1:0] rt;     // destination register index
  } mtc_dec_t;

  function automatic mtc_dec_t mtc_decode_word(input logic [MTC_W-1:0] w);
    mtc_dec_t d;
    d.hit   = (w[31:26] == OPC_MAJOR) && (w[20:17] == 4'b0000) &&
              (w[15:14] == 2'b00) && (w[13:11] == SEL_CODE) &&
              (w[9:3] == FUNC_CODE) && (w[2:0] == 3'b000);
    d.to_vp = ~w[16];
    d.sc    = w[10];
    d.rt    = w[25:21];
    return d;
  endfunction

  function automatic logic [MTC_W-1:0] mtc_put_bit(input logic [MTC_W-1:0] v,
                                                   input int unsigned pos,
                                                   input logic b);
    logic [MTC_W-1:0] r;
    r      = v;
    r[pos] = b;
    return r;
  endfunction
endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
(
  input  logic [MTC_W-1:0] word_i,
  output mtc_dec_t         dec_o
);
  always_comb dec_o = mtc_decode_word(word_i);
endmodule

// File: rtl/mtc_issue.sv
module mtc_issue
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  mtc_dec_t          dec_i,
  input  logic              cop0_en_i,
  input  logic              mt_ok_i,
  input  logic              master_i,
  output logic              fire_o,
  output logic              ok_o,
  output logic              cpu_o,
  output logic              ri_o,
  output logic              upd_thr_o,
  output logic              upd_vp_o,
  output logic              to_vp_o,
  output logic              sc_o,
  output logic [MTC_RW-1:0] rt_o
);
  logic accept;
  logic p_vld, p_cpu, p_ri, p_master, p_to_vp, p_sc;
  logic [MTC_RW-1:0] p_rt;

  assign accept = valid_i & dec_i.hit;

  // qualifiers are sampled with the word; coprocessor check ranks first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld    <= 1'b0;
      p_cpu    <= 1'b0;
      p_ri     <= 1'b0;
      p_master <= 1'b0;
      p_to_vp  <= 1'b0;
      p_sc     <= 1'b0;
      p_rt     <= '0;
    end else begin
      p_vld <= accept;
      if (accept) begin
        p_cpu    <= ~cop0_en_i;
        p_ri     <= cop0_en_i & ~mt_ok_i;
        p_master <= master_i;
        p_to_vp  <= dec_i.to_vp;
        p_sc     <= dec_i.sc;
        p_rt     <= dec_i.rt;
      end
    end
  end

  assign fire_o    = p_vld;
  assign cpu_o     = p_cpu;
  assign ri_o      = p_ri;
  assign ok_o      = p_vld & ~p_cpu & ~p_ri;
  assign upd_thr_o = ok_o & ~p_to_vp;
  assign upd_vp_o  = ok_o & p_to_vp & p_master;
  assign to_vp_o   = p_to_vp;
  assign sc_o      = p_sc;
  assign rt_o      = p_rt;

  // R3
  accept_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> fire_o);
  // R2
  ignore_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !fire_o);
endmodule

// File: rtl/mtc_ctl_regs.sv
module mtc_ctl_regs
  import mtc_pkg::*;
#(
  parameter int unsigned      TE_POS  = 15,
  parameter int unsigned      EVP_POS = 0,
  parameter logic [MTC_W-1:0] THR_RST = '0,
  parameter logic [MTC_W-1:0] VP_RST  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_thr_i,
  input  logic             upd_vp_i,
  input  logic             sc_i,
  output logic [MTC_W-1:0] thr_q,
  output logic [MTC_W-1:0] vp_q
);
  localparam logic [MTC_W-1:0] TE_MASK  = MTC_W'(1) << TE_POS;
  localparam logic [MTC_W-1:0] EVP_MASK = MTC_W'(1) << EVP_POS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      vp_q  <= VP_RST;
    end else begin
      if (upd_thr_i) thr_q <= mtc_put_bit(thr_q, TE_POS, sc_i);
      if (upd_vp_i)  vp_q  <= mtc_put_bit(vp_q, EVP_POS, sc_i);
    end
  end

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_thr_i |=> $stable(thr_q));
  // R7
  vp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vp_i |=> $stable(vp_q));
  // R5
  thr_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(thr_q & ~TE_MASK));
  // R6
  vp_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(vp_q & ~EVP_MASK));
endmodule

// File: rtl/mtc_result.sv
module mtc_result
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              ok_i,
  input  logic              cpu_i,
  input  logic              ri_i,
  input  logic              to_vp_i,
  input  logic [MTC_RW-1:0] rt_i,
  input  logic [MTC_W-1:0]  thr_q_i,
  input  logic [MTC_W-1:0]  vp_q_i,
  output logic              done_o,
  output logic              we_o,
  output logic [MTC_RW-1:0] idx_o,
  output logic [MTC_W-1:0]  data_o,
  output logic              exc_cpu_o,
  output logic              exc_ri_o
);
  logic [MTC_W-1:0] old_val;
  assign old_val = to_vp_i ? vp_q_i : thr_q_i;

  // old value is sampled at the same edge that updates the register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      we_o      <= 1'b0;
      idx_o     <= '0;
      data_o    <= '0;
      exc_cpu_o <= 1'b0;
      exc_ri_o  <= 1'b0;
    end else begin
      done_o    <= fire_i;
      we_o      <= ok_i & (rt_i != '0);
      exc_cpu_o <= fire_i & cpu_i;
      exc_ri_o  <= fire_i & ri_i;
      if (fire_i) begin
        idx_o  <= rt_i;
        data_o <= ok_i ? old_val : '0;
      end
    end
  end

  // R9
  exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_cpu_o && exc_ri_o));
  // R4
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (done_o && idx_o != '0));
  // R8
  exc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cpu_o || exc_ri_o) |-> (done_o && !we_o));
endmodule

// File: rtl/mtc_unit.sv
module mtc_unit
  import mtc_pkg::*;
#(
  parameter int unsigned      TE_POS  = 15,
  parameter int unsigned      EVP_POS = 0,
  parameter logic [MTC_W-1:0] THR_RST = '0,
  parameter logic [MTC_W-1:0] VP_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [MTC_W-1:0]  instr_word,
  input  logic              cop0_enabled,
  input  logic              mt_present,
  input  logic              is_master,
  output logic              op_done,
  output logic              gpr_we,
  output logic [MTC_RW-1:0] gpr_idx,
  output logic [MTC_W-1:0]  gpr_data,
  output logic              exc_cop_unusable,
  output logic              exc_reserved,
  output logic [MTC_W-1:0]  thr_ctl,
  output logic [MTC_W-1:0]  vp_ctl
);
  mtc_dec_t          dec;
  logic              fire, ok, cpu, ri, upd_thr, upd_vp, to_vp, sc;
  logic [MTC_RW-1:0] rt;

  mtc_decode u_dec (.word_i(instr_word), .dec_o(dec));

  mtc_issue u_iss (
    .clk(clk), .rst_n(rst_n), .valid_i(instr_valid), .dec_i(dec),
    .cop0_en_i(cop0_enabled), .mt_ok_i(mt_present), .master_i(is_master),
    .fire_o(fire), .ok_o(ok), .cpu_o(cpu), .ri_o(ri),
    .upd_thr_o(upd_thr), .upd_vp_o(upd_vp), .to_vp_o(to_vp),
    .sc_o(sc), .rt_o(rt)
  );

  mtc_ctl_regs #(.TE_POS(TE_POS), .EVP_POS(EVP_POS),
                 .THR_RST(THR_RST), .VP_RST(VP_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_thr_i(upd_thr), .upd_vp_i(upd_vp),
    .sc_i(sc), .thr_q(thr_ctl), .vp_q(vp_ctl)
  );

  mtc_result u_res (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .ok_i(ok), .cpu_i(cpu),
    .ri_i(ri), .to_vp_i(to_vp), .rt_i(rt), .thr_q_i(thr_ctl),
    .vp_q_i(vp_ctl), .done_o(op_done), .we_o(gpr_we), .idx_o(gpr_idx),
    .data_o(gpr_data), .exc_cpu_o(exc_cop_unusable), .exc_ri_o(exc_reserved)
  );

  // R8
  cpu_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_cop_unusable |-> ($stable(thr_ctl) && $stable(vp_ctl)));
  // R9
  ri_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_reserved |-> ($stable(thr_ctl) && $stable(vp_ctl)));
endmodule

// File: tb/mtc_unit_tb.sv
module mtc_unit_tb;
  localparam int unsigned TE_P  = 5;
  localparam int unsigned EVP_P = 9;
  localparam logic [31:0] T_RST = 32'hA5A5_0000;
  localparam logic [31:0] V_RST = 32'h0000_3C00;

  typedef struct {
    string       tag;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        ecpu;
    logic        eri;
    logic [31:0] thr;
    logic [31:0] vp;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, cop0_enabled = 1, mt_present = 1, is_master = 1;
  logic [31:0] instr_word = '0;
  logic op_done, gpr_we, exc_cop_unusable, exc_reserved;
  logic [4:0] gpr_idx;
  logic [31:0] gpr_data, thr_ctl, vp_ctl;

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [31:0] m_thr = T_RST, m_vp = V_RST;

  always #5 clk = ~clk;

  mtc_unit #(.TE_POS(TE_P), .EVP_POS(EVP_P), .THR_RST(T_RST), .VP_RST(V_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .cop0_enabled(cop0_enabled), .mt_present(mt_present), .is_master(is_master),
    .op_done(op_done), .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
    .exc_cop_unusable(exc_cop_unusable), .exc_reserved(exc_reserved),
    .thr_ctl(thr_ctl), .vp_ctl(vp_ctl));

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input bit vp, input bit sc);
    return {6'b001000, rt, 4'b0000, ~vp, 2'b00, 3'b001, sc, 7'b1010110, 3'b000};
  endfunction

  function automatic logic [31:0] force_bit(input logic [31:0] v, input int unsigned p,
                                            input bit s);
    logic [31:0] m;
    m = 32'h1 << p;
    return s ? (v | m) : (v & ~m);
  endfunction

  // driver: presents one instruction for one cycle and pushes its expectation
  task automatic send(input string tag, input logic [4:0] rt, input bit vp, input bit sc,
                      input bit c0, input bit mt, input bit ms);
    exp_t e;
    e.tag  = tag;
    e.ecpu = !c0;
    e.eri  = c0 && !mt;
    e.we   = 0;
    e.idx  = rt;
    e.data = vp ? m_vp : m_thr;
    if (c0 && mt) begin
      e.we = (rt != 0);
      if (!vp) m_thr = force_bit(m_thr, TE_P, sc);
      else if (ms) m_vp = force_bit(m_vp, EVP_P, sc);
    end
    e.thr = m_thr;
    e.vp  = m_vp;
    exp_q.push_back(e);
    instr_word = mk(rt, vp, sc);
    cop0_enabled = c0; mt_present = mt; is_master = ms;
    instr_valid = 1;
    @(negedge clk);
  endtask

  task automatic send_raw(input logic [31:0] w);
    instr_word = w; instr_valid = 1;
    cop0_enabled = 1; mt_present = 1; is_master = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    instr_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each completion against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && op_done) begin
      n_done++;
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(gpr_we == e.we, e.tag, "gpr_we", 32'(gpr_we), 32'(e.we));
        if (e.we) begin
          chk(gpr_idx == e.idx, e.tag, "gpr_idx", 32'(gpr_idx), 32'(e.idx));
          chk(gpr_data == e.data, e.tag, "gpr_data", gpr_data, e.data);
        end
        chk(exc_cop_unusable == e.ecpu, e.tag, "exc_cop_unusable",
            32'(exc_cop_unusable), 32'(e.ecpu));
        chk(exc_reserved == e.eri, e.tag, "exc_reserved", 32'(exc_reserved), 32'(e.eri));
        chk(thr_ctl == e.thr, e.tag, "thr_ctl", thr_ctl, e.thr);
        chk(vp_ctl == e.vp, e.tag, "vp_ctl", vp_ctl, e.vp);
      end
    end else if (rst_n) begin
      if (gpr_we || exc_cop_unusable || exc_reserved)
        chk(0, "R3", "strobe without completion", 32'd1, 32'd0);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(thr_ctl == T_RST, "R1", "thr_ctl in reset", thr_ctl, T_RST);
    chk(vp_ctl == V_RST, "R1", "vp_ctl in reset", vp_ctl, V_RST);
    rst_n = 1;
    @(negedge clk);
    chk(thr_ctl == T_RST, "R1", "thr_ctl after reset", thr_ctl, T_RST);
    chk(vp_ctl == V_RST, "R1", "vp_ctl after reset", vp_ctl, V_RST);
    chk(!op_done && !gpr_we && !exc_cop_unusable && !exc_reserved, "R1",
        "strobes after reset", {op_done, gpr_we, exc_cop_unusable, exc_reserved}, 0);

    // R3 R5: set and clear the thread bit
    send("R5_set", 5'd3, 0, 1, 1, 1, 1); idle(3);
    send("R4_zero_dest", 5'd0, 0, 0, 1, 1, 1); idle(3);
    send("R5_set_again", 5'd17, 0, 1, 1, 1, 1); idle(3);
    // R6: processor bit as master
    send("R6_set", 5'd7, 1, 1, 1, 1, 1); idle(3);
    send("R6_clear", 5'd31, 1, 0, 1, 1, 1); idle(3);
    // R7: not master
    send("R7_set_blocked", 5'd9, 1, 1, 1, 1, 0); idle(3);
    // R8 R9 exceptions
    send("R8_cop_off", 5'd4, 0, 0, 0, 1, 1); idle(3);
    send("R9_both_off", 5'd4, 1, 0, 0, 0, 1); idle(3);
    send("R9_no_mt", 5'd6, 0, 0, 1, 0, 1); idle(3);
    // R10 back to back
    send("R10_a", 5'd1, 0, 0, 1, 1, 1);
    send("R10_b", 5'd2, 0, 1, 1, 1, 1);
    send("R10_c", 5'd3, 1, 1, 1, 1, 1);
    send("R10_d", 5'd4, 1, 0, 1, 1, 1);
    send("R10_e", 5'd5, 0, 0, 1, 1, 1);
    idle(4);

    // R2 near-miss words have no effect
    d0 = n_done;
    send_raw(mk(5'd3, 0, 1) ^ 32'h8000_0000);
    send_raw(mk(5'd3, 0, 1) | 32'h0002_0000);
    send_raw(mk(5'd3, 1, 1) ^ 32'h0000_0800);
    send_raw(mk(5'd3, 1, 1) | 32'h0000_4000);
    send_raw(mk(5'd3, 0, 1) | 32'h0000_0001);
    send_raw(mk(5'd3, 1, 1) ^ 32'h0000_0008);
    idle(4);
    chk(n_done == d0, "R2", "completions for bad words", 32'(n_done - d0), 0);
    chk(thr_ctl == m_thr, "R2", "thr_ctl after bad words", thr_ctl, m_thr);
    chk(vp_ctl == m_vp, "R2", "vp_ctl after bad words", vp_ctl, m_vp);
    // valid low with a good word present
    instr_word = mk(5'd3, 1, 1);
    repeat (3) @(negedge clk);
    chk(n_done == d0, "R2", "completion without valid", 32'(n_done - d0), 0);

    chk(exp_q.size() == 0, "R3", "missing completions", 32'(exp_q.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule